// File: doc/BRIEF.md
# Address-Triggered Load/Store Register File

This block holds three banks of eight registers. The address bank holds 18-bit addresses, the index bank holds 18-bit offsets, and the data bank holds 60-bit operands. Memory is never addressed directly. Writing an address register stores the value and also starts one memory transfer for the data register with the same number. Address registers 0 through 5 start a load into their data register. Address registers 6 and 7 start a store from their data register.

The memory word address is the written address value plus the index register picked on the same write, wrapped to 18 bits. Index register 0 is fixed at zero, so it gives absolute addressing. A separate write port puts arithmetic results into the data bank. Only one transfer is in flight at a time. While a transfer is running, the address write port shows not-ready and ignores any write.

Top module: `addr_trig_regfile`

## Requirements
- R1: After reset, every A, B and X register reads zero, `busy` and `mem_req` are low, and `a_wr_ready` is high.
- R2: An accepted write to A0..A5 starts a load. In the next cycle `mem_req`=1 and `mem_we`=0. In the cycle where `mem_ready`=1 is seen, `mem_rdata` is written into the X register with the same number.
- R3: An accepted write to A6 or A7 starts a store. In the next cycle `mem_req`=1 and `mem_we`=1, and `mem_wdata` carries that X register.
- R4: `mem_addr` equals the written A value plus the B register chosen by `a_wr_bsel`, modulo 2^18. The B value used is the one held before that clock edge.
- R5: B0 always reads zero. Writes to B0 have no effect, so `a_wr_bsel`=0 gives the plain A value as the address.
- R6: While a transfer is in progress, `busy`=1 and `a_wr_ready`=0. An A write offered in that time changes no A register and starts no transfer.
- R7: The store data is the X value held at the edge where the A write is accepted. Later writes to that X register do not change `mem_wdata`.
- R8: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay steady until `mem_ready` is seen. `mem_req` drops in the cycle after that, and `a_wr_ready` returns high.
- R9: The X write port updates the selected X register at the clock edge. If a load finishes on the same register in the same cycle, the memory word wins.
- R10: The read ports are combinational. They return the selected A, B and X register contents, and an accepted A write is visible on the A read port after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Address register write request |
| a_wr_sel | input | 3 | Address register number |
| a_wr_val | input | 18 | Address value |
| a_wr_bsel | input | 3 | Index register added to form the memory address |
| a_wr_ready | output | 1 | Address write accepted in this cycle when high |
| b_wr_en | input | 1 | Index register write |
| b_wr_sel | input | 3 | Index register number |
| b_wr_val | input | 18 | Index value |
| x_wr_en | input | 1 | Data register write (arithmetic result) |
| x_wr_sel | input | 3 | Data register number |
| x_wr_val | input | 60 | Data value |
| a_rd_sel | input | 3 | Address read select |
| a_rd_val | output | 18 | Address read data |
| b_rd_sel | input | 3 | Index read select |
| b_rd_val | output | 18 | Index read data |
| x_rd_sel | input | 3 | Data read select |
| x_rd_val | output | 60 | Data read data |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable (store) |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 60 | Store data |
| mem_rdata | input | 60 | Load data |
| mem_ready | input | 1 | Memory completes the request in this cycle |

## Verification
The bench targets several corner cases. It stalls A writes during a transfer: a design that accepted them would corrupt an A register or issue a second request. It rewrites the stored X register while a store waits: a design that read X late would send the new value. It writes B0 and then uses index 0: a design that kept the value would offset the address. It picks index values close to 2^18 to check that the sum wraps. It also writes the loading X register through the arithmetic port in the very cycle memory answers: a design with the wrong priority would keep the arithmetic value instead of the memory word.

// File: rtl/atrf_pkg.sv
package atrf_pkg;
  typedef enum logic {XFER_LOAD = 1'b0, XFER_STORE = 1'b1} xfer_dir_e;

  function automatic xfer_dir_e dir_of(input int unsigned sel, input int unsigned store_first);
    return (sel >= store_first) ? XFER_STORE : XFER_LOAD;
  endfunction
endpackage

// File: rtl/atrf_addr_file.sv
module atrf_addr_file #(
  parameter int AW   = 18,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [SW-1:0] a_sel,
  input  logic [AW-1:0] a_val,
  input  logic          b_we,
  input  logic [SW-1:0] b_sel,
  input  logic [AW-1:0] b_val,
  input  logic [SW-1:0] a_rd_sel,
  output logic [AW-1:0] a_rd_val,
  input  logic [SW-1:0] b_rd_sel,
  output logic [AW-1:0] b_rd_val,
  input  logic [SW-1:0] idx_sel,
  output logic [AW-1:0] idx_val
);
  logic [AW-1:0] a_q [NREG];
  logic [AW-1:0] b_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) a_q[i] <= '0;
      else if (a_we && a_sel == SW'(i)) a_q[i] <= a_val;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_idx
    if (g == 0) begin : g_zero
      assign b_q[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) b_q[g] <= '0;
        else if (b_we && b_sel == SW'(g)) b_q[g] <= b_val;
      end
    end
  end

  assign a_rd_val = a_q[a_rd_sel];
  assign b_rd_val = b_q[b_rd_sel];
  assign idx_val  = b_q[idx_sel];
endmodule

// File: rtl/atrf_data_file.sv
module atrf_data_file #(
  parameter int DW   = 60,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ar_we,
  input  logic [SW-1:0] ar_sel,
  input  logic [DW-1:0] ar_val,
  input  logic          ld_we,
  input  logic [SW-1:0] ld_sel,
  input  logic [DW-1:0] ld_val,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_val,
  input  logic [SW-1:0] st_sel,
  output logic [DW-1:0] st_val
);
  logic [DW-1:0] x_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_x
    always_ff @(posedge clk) begin
      if (!rst_n) x_q[g] <= '0;
      else if (ld_we && ld_sel == SW'(g)) x_q[g] <= ld_val;
      else if (ar_we && ar_sel == SW'(g)) x_q[g] <= ar_val;
    end
  end

  assign rd_val = x_q[rd_sel];
  assign st_val = x_q[st_sel];
endmodule

// File: rtl/atrf_xfer_ctrl.sv
module atrf_xfer_ctrl
  import atrf_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 60,
  parameter int NREG        = 8,
  parameter int STORE_FIRST = 6,
  localparam int SW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [DW-1:0] st_data,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  output logic          ld_done,
  output logic [SW-1:0] ld_sel
);
  function automatic logic [AW-1:0] eff_addr(input logic [AW-1:0] b, input logic [AW-1:0] i);
    return b + i;
  endfunction

  logic          busy_q;
  xfer_dir_e     dir_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [SW-1:0] sel_q;
  logic          finish;

  assign finish = busy_q && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= XFER_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      dir_q   <= dir_of(int'(sel), STORE_FIRST);
      addr_q  <= eff_addr(base, index);
      wdata_q <= st_data;
      sel_q   <= sel;
    end else if (finish) begin
      busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_we    = (dir_q == XFER_STORE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign ld_done   = finish && (dir_q == XFER_LOAD);
  assign ld_sel    = sel_q;
endmodule

// File: rtl/addr_trig_regfile.sv
module addr_trig_regfile #(
  parameter int AW          = 18,
  parameter int DW          = 60,
  parameter int NREG        = 8,
  parameter int STORE_FIRST = 6,
  localparam int SW         = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic [SW-1:0] a_wr_sel,
  input  logic [AW-1:0] a_wr_val,
  input  logic [SW-1:0] a_wr_bsel,
  output logic          a_wr_ready,
  input  logic          b_wr_en,
  input  logic [SW-1:0] b_wr_sel,
  input  logic [AW-1:0] b_wr_val,
  input  logic          x_wr_en,
  input  logic [SW-1:0] x_wr_sel,
  input  logic [DW-1:0] x_wr_val,
  input  logic [SW-1:0] a_rd_sel,
  output logic [AW-1:0] a_rd_val,
  input  logic [SW-1:0] b_rd_sel,
  output logic [AW-1:0] b_rd_val,
  input  logic [SW-1:0] x_rd_sel,
  output logic [DW-1:0] x_rd_val,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  logic          a_accept;
  logic [AW-1:0] idx_val;
  logic [DW-1:0] st_val;
  logic          ld_done;
  logic [SW-1:0] ld_sel;

  assign a_wr_ready = !busy;
  assign a_accept   = a_wr_en && a_wr_ready;

  atrf_addr_file #(.AW(AW), .NREG(NREG)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_accept), .a_sel(a_wr_sel), .a_val(a_wr_val),
    .b_we(b_wr_en), .b_sel(b_wr_sel), .b_val(b_wr_val),
    .a_rd_sel(a_rd_sel), .a_rd_val(a_rd_val),
    .b_rd_sel(b_rd_sel), .b_rd_val(b_rd_val),
    .idx_sel(a_wr_bsel), .idx_val(idx_val)
  );

  atrf_data_file #(.DW(DW), .NREG(NREG)) u_data (
    .clk(clk), .rst_n(rst_n),
    .ar_we(x_wr_en), .ar_sel(x_wr_sel), .ar_val(x_wr_val),
    .ld_we(ld_done), .ld_sel(ld_sel), .ld_val(mem_rdata),
    .rd_sel(x_rd_sel), .rd_val(x_rd_val),
    .st_sel(a_wr_sel), .st_val(st_val)
  );

  atrf_xfer_ctrl #(.AW(AW), .DW(DW), .NREG(NREG), .STORE_FIRST(STORE_FIRST)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(a_accept), .sel(a_wr_sel), .base(a_wr_val), .index(idx_val),
    .st_data(st_val),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .ld_done(ld_done), .ld_sel(ld_sel)
  );
endmodule

// File: rtl/atrf_chk.sv
module atrf_chk #(
  parameter int AW          = 18,
  parameter int DW          = 60,
  parameter int SW          = 3,
  parameter int STORE_FIRST = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_wr_en,
  input logic [SW-1:0] a_wr_sel,
  input logic          a_wr_ready,
  input logic [SW-1:0] b_rd_sel,
  input logic [AW-1:0] b_rd_val,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          ld_done
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> !mem_req);

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !a_wr_ready);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en && a_wr_ready) |=> (mem_req && (mem_we == ($past(a_wr_sel) >= SW'(STORE_FIRST)))));

  // R5
  b0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd_sel == '0) |-> (b_rd_val == '0));

  // R2
  ld_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (mem_req && !mem_we));
endmodule

bind addr_trig_regfile atrf_chk #(.AW(AW), .DW(DW), .SW(SW), .STORE_FIRST(STORE_FIRST)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_wr_en(a_wr_en), .a_wr_sel(a_wr_sel),
  .a_wr_ready(a_wr_ready), .b_rd_sel(b_rd_sel), .b_rd_val(b_rd_val),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .ld_done(ld_done)
);

// File: tb/addr_trig_regfile_test.sv
module addr_trig_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_wr_en = 0;
  logic [2:0]  a_wr_sel = 0;
  logic [17:0] a_wr_val = 0;
  logic [2:0]  a_wr_bsel = 0;
  logic        a_wr_ready;
  logic        b_wr_en = 0;
  logic [2:0]  b_wr_sel = 0;
  logic [17:0] b_wr_val = 0;
  logic        x_wr_en = 0;
  logic [2:0]  x_wr_sel = 0;
  logic [59:0] x_wr_val = 0;
  logic [2:0]  a_rd_sel = 0, b_rd_sel = 0, x_rd_sel = 0;
  logic [17:0] a_rd_val, b_rd_val;
  logic [59:0] x_rd_val;
  logic        busy, mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata;
  logic [59:0] mem_rdata = 0;
  logic        mem_ready = 0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [17:0] mA [8];
  logic [17:0] mB [8];
  logic [59:0] mX [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_trig_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_sel(a_wr_sel), .a_wr_val(a_wr_val), .a_wr_bsel(a_wr_bsel),
    .a_wr_ready(a_wr_ready),
    .b_wr_en(b_wr_en), .b_wr_sel(b_wr_sel), .b_wr_val(b_wr_val),
    .x_wr_en(x_wr_en), .x_wr_sel(x_wr_sel), .x_wr_val(x_wr_val),
    .a_rd_sel(a_rd_sel), .a_rd_val(a_rd_val),
    .b_rd_sel(b_rd_sel), .b_rd_val(b_rd_val),
    .x_rd_sel(x_rd_sel), .x_rd_val(x_rd_val),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [59:0] mem_word(input logic [17:0] ad);
    return {ad, ~ad, 6'h2A, ad ^ 18'h15A5A};
  endfunction

  function automatic logic [17:0] exp_addr(input logic [17:0] v, input logic [2:0] bs);
    logic [18:0] s;
    s = {1'b0, v} + {1'b0, (bs == 0) ? 18'd0 : mB[bs]};
    return s[17:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input logic [2:0] s);
    a_rd_sel = s; b_rd_sel = s; x_rd_sel = s;
    #1;
    chk(a_rd_val == mA[s], "R10 A read", 64'(a_rd_val), 64'(mA[s]));
    chk(b_rd_val == mB[s], "R5/R10 B read", 64'(b_rd_val), 64'(mB[s]));
    chk(x_rd_val == mX[s], "R9/R10 X read", 64'(x_rd_val), 64'(mX[s]));
  endtask

  task automatic wr_b(input logic [2:0] s, input logic [17:0] v);
    @(negedge clk);
    b_wr_en = 1; b_wr_sel = s; b_wr_val = v;
    @(negedge clk);
    b_wr_en = 0;
    if (s != 0) mB[s] = v;
  endtask

  task automatic wr_x(input logic [2:0] s, input logic [59:0] v);
    @(negedge clk);
    x_wr_en = 1; x_wr_sel = s; x_wr_val = v;
    @(negedge clk);
    x_wr_en = 0;
    mX[s] = v;
  endtask

  // One triggered transfer; lat wait cycles before ready.
  // stall: offer A writes while busy; xhit: write the paired X during the wait;
  // clash: arithmetic write to the loading X in the completion cycle.
  task automatic a_op(input logic [2:0] s, input logic [17:0] v, input logic [2:0] bs,
                      input int lat, input bit stall, input bit xhit, input bit clash);
    logic [17:0] ea;
    logic [59:0] sd;
    bit          st;
    logic [2:0]  other;
    @(negedge clk);
    chk(a_wr_ready == 1'b1, "R8 ready before write", 64'(a_wr_ready), 64'd1);
    ea = exp_addr(v, bs);
    sd = mX[s];
    st = (s >= 3'd6);
    a_wr_en = 1; a_wr_sel = s; a_wr_val = v; a_wr_bsel = bs;
    mA[s] = v;
    @(negedge clk);
    a_wr_en = 0;
    chk(mem_req == 1'b1 && busy == 1'b1, "R2/R3 request raised", 64'({mem_req, busy}), 64'd3);
    chk(mem_we == st, st ? "R3 store direction" : "R2 load direction", 64'(mem_we), 64'(st));
    chk(mem_addr == ea, "R4 effective address", 64'(mem_addr), 64'(ea));
    if (st) chk(mem_wdata == sd, "R3 store data", 64'(mem_wdata), 64'(sd));
    for (int i = 0; i < lat; i++) begin
      other = s + 3'd1;
      if (stall) begin
        a_wr_en = 1; a_wr_sel = other; a_wr_val = v ^ 18'h3FFFF; a_wr_bsel = 0;
        chk(a_wr_ready == 1'b0, "R6 not ready while busy", 64'(a_wr_ready), 64'd0);
      end
      if (xhit) begin
        x_wr_en = 1; x_wr_sel = s; x_wr_val = {$urandom(), $urandom()};
        mX[s] = x_wr_val;
      end
      @(negedge clk);
      a_wr_en = 0; x_wr_en = 0;
      chk(mem_req == 1'b1 && mem_addr == ea, "R8 request held", 64'(mem_addr), 64'(ea));
      if (st) chk(mem_wdata == sd, "R7 store data captured", 64'(mem_wdata), 64'(sd));
    end
    mem_ready = 1; mem_rdata = mem_word(ea);
    if (clash) begin
      x_wr_en = 1; x_wr_sel = s; x_wr_val = 60'h0F0F0F0F0F0F0F0;
      mX[s] = x_wr_val;
    end
    @(negedge clk);
    mem_ready = 0; x_wr_en = 0;
    if (!st) mX[s] = mem_word(ea);
    chk(mem_req == 1'b0 && busy == 1'b0, "R8 request dropped", 64'({mem_req, busy}), 64'd0);
    chk(a_wr_ready == 1'b1, "R8 ready restored", 64'(a_wr_ready), 64'd1);
    check_regs(s);
    if (stall) check_regs(s + 3'd1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mA[i] = 0; mB[i] = 0; mX[i] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && mem_req == 0, "R1 idle after reset", 64'({busy, mem_req}), 64'd0);
    chk(a_wr_ready == 1, "R1 ready after reset", 64'(a_wr_ready), 64'd1);
    for (int i = 0; i < 8; i++) check_regs(3'(i));

    // R5: B0 write ignored, index 0 gives plain address
    wr_b(3'd0, 18'h00055);
    check_regs(3'd0);
    a_op(3'd0, 18'h01234, 3'd0, 0, 0, 0, 0);
    // R4: wrap modulo 2^18
    wr_b(3'd3, 18'h3FFFF);
    a_op(3'd2, 18'h00005, 3'd3, 2, 1, 0, 0);
    // R3/R7: stores with the X register rewritten while waiting
    wr_x(3'd6, 60'h123456789ABCDEF);
    a_op(3'd6, 18'h00100, 3'd0, 3, 1, 1, 0);
    wr_x(3'd7, 60'hFEDCBA987654321);
    a_op(3'd7, 18'h3FF00, 3'd3, 1, 0, 1, 0);
    // R9: load completion beats arithmetic write in the same cycle
    a_op(3'd4, 18'h0ABCD, 3'd0, 1, 0, 0, 1);
    // R2: load with X written during the wait, then overwritten by memory
    a_op(3'd5, 18'h00777, 3'd3, 2, 0, 1, 0);

    // Random mix
    for (int k = 0; k < 80; k++) begin
      if ($urandom_range(0, 1) == 1) wr_b(3'($urandom_range(0, 7)), 18'($urandom()));
      if ($urandom_range(0, 1) == 1) wr_x(3'($urandom_range(0, 7)), {$urandom(), $urandom()});
      a_op(3'($urandom_range(0, 7)), 18'($urandom()), 3'($urandom_range(0, 7)),
           int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    for (int i = 0; i < 8; i++) check_regs(3'(i));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule